// File: doc/BRIEF.md
# PCM Serial Audio Port

This block is a full-duplex synchronous serial port for digital audio. It runs as a slave. An external master supplies the bit clock `pcm_clk` and the frame strobe `pcm_frame`, and the port never drives either one. In each frame it shifts one parallel word out on `pcm_out` and gathers one word from `pcm_in`. Transmit words enter through a valid/ready handshake into a single holding register. Received words leave through a second valid/ready handshake from a single output register.

Four static configuration bits choose the framing, which gives sixteen variants:

- word length: 16 or 32 bits;
- bit order: LSB first or MSB first;
- alignment: advanced or delayed;
- frame strobe width: short or wide.

The external clock, frame and data lines pass through a synchroniser into the system clock domain. Each rising edge of the bit clock is then handled as a single-cycle event.

A frame controller steps through three states: `FS_IDLE`, `FS_LEAD` and `FS_DATA`.

- `FS_IDLE` moves to `FS_DATA` when a frame starts in advanced mode. In delayed mode it moves to `FS_LEAD` instead.
- `FS_LEAD` always moves to `FS_DATA` on the next bit edge, which carries bit 0.
- `FS_DATA` counts the bits. On the last bit it returns to `FS_IDLE`, or to `FS_LEAD` when a new delayed frame begins on that same edge.
- A frame start seen in `FS_DATA` at any other point aborts the word and restarts the count.

The controller also raises one-cycle pulses for underrun, overrun and framing errors.

Top module: `pcm_serial_port`

## Requirements
- R1: After reset, `tx_ready` is 1, `rx_valid` is 0, `pcm_out` is 0, and `underrun`, `overrun` and `frame_err` are all 0.
- R2: With `cfg_word32`=0 a word has 16 bits: only bits 15:0 of `tx_data` are sent, and bits 31:16 of `rx_data` read 0. With `cfg_word32`=1 a word has 32 bits.
- R3: With `cfg_msb_first`=0 data bit i of the frame is word bit i. With `cfg_msb_first`=1 data bit i is word bit N-1-i. The same order applies to both directions.
- R4: A frame starts at the bit-clock rising edge where `pcm_frame` is sampled 1 after being sampled 0 at the previous edge.
  - With `cfg_delayed`=0, data bit 0 is captured from `pcm_in` at that edge and is driven on `pcm_out` just after it.
  - With `cfg_delayed`=1, all of this happens one bit edge later.
  - Each further bit follows on the next edge.
- R5: In delayed mode, a new frame may start on the edge that carries the last bit of the previous word. Both words then complete and no error is flagged.
- R6: When the last bit of a received word is captured, `rx_valid` is set with the word on `rx_data`. `rx_valid` holds until `rx_ready` is seen high.
- R7: If a word completes while `rx_valid` is still high and `rx_ready` is low, `overrun` pulses for one cycle and the newer word replaces the older one.
- R8: `tx_ready` is high while the transmit holding register is empty. A word accepted with `tx_valid` fills it. The register is emptied into the shifter at each frame start.
- R9: If a frame starts while the holding register is empty, zero is sent for that word and `underrun` pulses for one cycle.
- R10: A frame start in `FS_DATA` that is not the R5 case pulses `frame_err` once and discards the partial received word. The port then runs the new frame from its own start.
- R11: With `cfg_wide_pulse`=0, if `pcm_frame` is still 1 at the bit edge after a frame start, `frame_err` pulses once. The word still completes.
- R12: With `cfg_wide_pulse`=1, the strobe must stay 1 through the last data edge. If it falls while a word is in progress, `frame_err` pulses once and the word still completes.
- R13: `pcm_out` is 0 after any bit edge that carries no data bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_word32 | input | 1 | 1 selects 32-bit words, 0 selects 16-bit |
| cfg_msb_first | input | 1 | 1 shifts the most significant bit first |
| cfg_delayed | input | 1 | 1 places bit 0 one bit edge after the frame start |
| cfg_wide_pulse | input | 1 | 1 expects a frame strobe lasting the whole word |
| pcm_clk | input | 1 | External bit clock |
| pcm_frame | input | 1 | External frame strobe |
| pcm_in | input | 1 | Serial receive data |
| pcm_out | output | 1 | Serial transmit data |
| tx_data | input | MAX_W | Word to transmit |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit holding register empty |
| rx_data | output | MAX_W | Received word |
| rx_valid | output | 1 | Received word present |
| rx_ready | input | 1 | Received word taken |
| underrun | output | 1 | Frame started with no transmit word |
| overrun | output | 1 | Received word overwritten before it was taken |
| frame_err | output | 1 | Frame strobe arrived early or had the wrong width |

## Verification
The bench goes after the following corner cases:

- **Back-to-back delayed frames.** The second strobe lands on the last data bit of the first frame. A controller that treats this as an early strobe would lose the first word and flag an error.
- **Early strobe in the middle of a word.** A design that failed to resynchronise would deliver a mixed word, or would shift the second frame by several bits.
- **Strobes that are too long or end too soon.** These must give exactly one error pulse while the word still arrives intact.
- **Underrun and overrun.** The bench checks for zeros on the line and for the newer word winning.

Every table entry also checks the data both ways and the idle line level. A design with a swapped bit order, a wrong alignment or an unmasked 16-bit word would therefore show shifted or reversed values.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_LEAD = 2'd1,
        FS_DATA = 2'd2
    } frame_state_e;

    typedef struct packed {
        logic word32;
        logic msb_first;
        logic delayed;
        logic wide_pulse;
    } pcm_cfg_t;

endpackage

// File: rtl/pcm_edge_sync.sv
module pcm_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pcm_clk,
    input  logic pcm_frame,
    input  logic pcm_in,
    output logic bit_edge,
    output logic frame_s,
    output logic din_s
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [2:0] raw;
    logic [2:0] stg [SYNC_STAGES];
    logic       clk_prev;

    assign raw = {pcm_clk, pcm_frame, pcm_in};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= '0;
            clk_prev <= 1'b0;
        end else begin
            stg[0] <= raw;
            for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
            clk_prev <= stg[LAST][2];
        end
    end

    assign bit_edge = stg[LAST][2] & ~clk_prev;
    assign frame_s  = stg[LAST][1];
    assign din_s    = stg[LAST][0];
endmodule

// File: rtl/pcm_frame_ctrl.sv
module pcm_frame_ctrl
    import pcm_port_pkg::*;
#(
    parameter int MAX_W   = 32,
    parameter int SHORT_W = 16,
    localparam int IDX_W  = $clog2(MAX_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pcm_cfg_t         cfg,
    input  logic             bit_edge,
    input  logic             frame_s,
    output logic             start,
    output logic             dat_en,
    output logic [IDX_W-1:0] dat_idx,
    output logic             done,
    output logic [IDX_W-1:0] nbits_m1,
    output logic             frame_err
);
    frame_state_e     state, nstate;
    logic [IDX_W-1:0] idx, nidx;
    logic             frame_prev, rise_prev;
    logic             rise, early, short_bad, wide_bad, seq_done;

    assign nbits_m1 = cfg.word32 ? IDX_W'(MAX_W - 1) : IDX_W'(SHORT_W - 1);
    assign rise     = bit_edge & frame_s & ~frame_prev;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= FS_IDLE;
            idx        <= '0;
            frame_prev <= 1'b0;
            rise_prev  <= 1'b0;
            frame_err  <= 1'b0;
        end else begin
            state     <= nstate;
            idx       <= nidx;
            frame_err <= early | short_bad | wide_bad;
            if (bit_edge) begin
                frame_prev <= frame_s;
                rise_prev  <= rise;
            end
        end
    end

    // next state and per-edge outputs
    always_comb begin
        nstate   = state;
        nidx     = idx;
        start    = 1'b0;
        dat_en   = 1'b0;
        dat_idx  = idx;
        seq_done = 1'b0;
        early    = 1'b0;
        if (bit_edge) begin
            unique case (state)
                FS_IDLE: ;
                FS_LEAD: begin
                    dat_en  = 1'b1;
                    dat_idx = '0;
                    nidx    = IDX_W'(1);
                    nstate  = FS_DATA;
                end
                FS_DATA: begin
                    dat_en  = 1'b1;
                    dat_idx = idx;
                    if (idx == nbits_m1) begin
                        seq_done = 1'b1;
                        nstate   = FS_IDLE;
                    end else begin
                        nidx = idx + 1'b1;
                    end
                end
                default: nstate = FS_IDLE;
            endcase
            if (rise) begin
                start = 1'b1;
                if (state != FS_IDLE && !(seq_done && cfg.delayed)) early = 1'b1;
                if (cfg.delayed) begin
                    nstate = FS_LEAD;
                    nidx   = '0;
                end else begin
                    dat_en  = 1'b1;
                    dat_idx = '0;
                    nidx    = IDX_W'(1);
                    nstate  = FS_DATA;
                end
            end
        end
        done = seq_done & ~early;
    end

    assign short_bad = bit_edge & ~cfg.wide_pulse & frame_s & rise_prev;
    assign wide_bad  = bit_edge & cfg.wide_pulse & ~frame_s & frame_prev &
                       (state != FS_IDLE);
endmodule

// File: rtl/pcm_tx_path.sv
module pcm_tx_path #(
    parameter int MAX_W  = 32,
    localparam int IDX_W = $clog2(MAX_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MAX_W-1:0] tx_data,
    input  logic             tx_valid,
    output logic             tx_ready,
    input  logic             bit_edge,
    input  logic             start,
    input  logic             dat_en,
    input  logic [IDX_W-1:0] dat_idx,
    input  logic [IDX_W-1:0] nbits_m1,
    input  logic             msb_first,
    output logic             pcm_out,
    output logic             underrun
);
    logic [MAX_W-1:0] hold_q, word_q, new_word, cur_word;
    logic             hold_full, accept;
    logic [IDX_W-1:0] pos;

    assign accept   = tx_valid & ~hold_full;
    assign tx_ready = ~hold_full;
    assign new_word = hold_full ? hold_q : '0;
    assign cur_word = (start && dat_en && dat_idx == '0) ? new_word : word_q;
    assign pos      = msb_first ? (nbits_m1 - dat_idx) : dat_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q    <= '0;
            hold_full <= 1'b0;
            word_q    <= '0;
            pcm_out   <= 1'b0;
            underrun  <= 1'b0;
        end else begin
            if (accept) hold_q <= tx_data;
            hold_full <= (hold_full & ~start) | accept;
            if (start) word_q <= new_word;
            underrun <= start & ~hold_full;
            if (bit_edge) pcm_out <= dat_en ? cur_word[pos] : 1'b0;
        end
    end
endmodule

// File: rtl/pcm_rx_path.sv
module pcm_rx_path #(
    parameter int MAX_W  = 32,
    localparam int IDX_W = $clog2(MAX_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    input  logic             dat_en,
    input  logic [IDX_W-1:0] dat_idx,
    input  logic             done,
    input  logic [IDX_W-1:0] nbits_m1,
    input  logic             msb_first,
    output logic [MAX_W-1:0] rx_data,
    output logic             rx_valid,
    input  logic             rx_ready,
    output logic             overrun
);
    logic [MAX_W-1:0] acc, acc_next;
    logic [IDX_W-1:0] pos;

    assign pos = msb_first ? (nbits_m1 - dat_idx) : dat_idx;

    always_comb begin
        acc_next      = (dat_idx == '0) ? '0 : acc;
        acc_next[pos] = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc      <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
            overrun  <= 1'b0;
        end else begin
            overrun <= 1'b0;
            if (dat_en) acc <= acc_next;
            if (done) begin
                rx_data  <= acc_next;
                rx_valid <= 1'b1;
                overrun  <= rx_valid & ~rx_ready;
            end else if (rx_ready) begin
                rx_valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port
    import pcm_port_pkg::*;
#(
    parameter int MAX_W       = 32,
    parameter int SHORT_W     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_word32,
    input  logic             cfg_msb_first,
    input  logic             cfg_delayed,
    input  logic             cfg_wide_pulse,
    input  logic             pcm_clk,
    input  logic             pcm_frame,
    input  logic             pcm_in,
    output logic             pcm_out,
    input  logic [MAX_W-1:0] tx_data,
    input  logic             tx_valid,
    output logic             tx_ready,
    output logic [MAX_W-1:0] rx_data,
    output logic             rx_valid,
    input  logic             rx_ready,
    output logic             underrun,
    output logic             overrun,
    output logic             frame_err
);
    localparam int IDX_W = $clog2(MAX_W);

    pcm_cfg_t         cfg;
    logic             bit_edge, frame_s, din_s;
    logic             start, dat_en, done;
    logic [IDX_W-1:0] dat_idx, nbits_m1;

    assign cfg = '{word32: cfg_word32, msb_first: cfg_msb_first,
                   delayed: cfg_delayed, wide_pulse: cfg_wide_pulse};

    pcm_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pcm_clk(pcm_clk), .pcm_frame(pcm_frame),
        .pcm_in(pcm_in), .bit_edge(bit_edge), .frame_s(frame_s), .din_s(din_s)
    );

    pcm_frame_ctrl #(.MAX_W(MAX_W), .SHORT_W(SHORT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .bit_edge(bit_edge),
        .frame_s(frame_s), .start(start), .dat_en(dat_en), .dat_idx(dat_idx),
        .done(done), .nbits_m1(nbits_m1), .frame_err(frame_err)
    );

    pcm_tx_path #(.MAX_W(MAX_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .bit_edge(bit_edge), .start(start),
        .dat_en(dat_en), .dat_idx(dat_idx), .nbits_m1(nbits_m1),
        .msb_first(cfg.msb_first), .pcm_out(pcm_out), .underrun(underrun)
    );

    pcm_rx_path #(.MAX_W(MAX_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .din(din_s), .dat_en(dat_en),
        .dat_idx(dat_idx), .done(done), .nbits_m1(nbits_m1),
        .msb_first(cfg.msb_first), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_ready(rx_ready), .overrun(overrun)
    );
endmodule

// File: rtl/pcm_serial_port_chk.sv
module pcm_serial_port_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_valid,
    input logic tx_ready,
    input logic rx_valid,
    input logic rx_ready,
    input logic underrun,
    input logic overrun,
    input logic frame_err
);
    p_tx_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready |=> !tx_ready);

    p_tx_keep_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready && !tx_valid |=> tx_ready);

    p_rx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && !rx_ready |=> rx_valid);

    p_ovr_with_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> rx_valid);

    p_udr_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> !underrun);

    p_err_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> !frame_err);
endmodule

bind pcm_serial_port pcm_serial_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .underrun(underrun),
    .overrun(overrun), .frame_err(frame_err)
);

// File: tb/test_pcm_serial_port.sv
module test_pcm_serial_port;
    logic        clk = 0, rst_n = 0;
    logic        c_w32 = 0, c_msb = 0, c_del = 0, c_wide = 0;
    logic        pcm_clk = 0, pcm_frame = 0, pcm_in = 0, pcm_out;
    logic [31:0] tx_data = '0, rx_data;
    logic        tx_valid = 0, tx_ready, rx_valid, rx_ready = 1;
    logic        underrun, overrun, frame_err;

    int n_tests = 0, n_fail = 0;
    int n_udr = 0, n_ovr = 0, n_err = 0, rx_n = 0;
    logic [31:0] rx_log [0:63];
    logic fr_seq [0:127];
    logic din_seq [0:127];
    logic out_seq [0:127];
    int seq_len = 0;
    bit done_flag = 0;

    // {word32, msb_first, delayed, wide_pulse}, tx word, rx word
    localparam logic [67:0] VEC [0:7] = '{
        {4'b0000, 32'h0000A5C3, 32'h00001234},
        {4'b0100, 32'h00008001, 32'h0000F00D},
        {4'b0010, 32'hDEADBEEF, 32'h13579BDF},
        {4'b0001, 32'h00007E81, 32'h00003C5A},
        {4'b1000, 32'hCAFEF00D, 32'h80000001},
        {4'b1110, 32'h12345678, 32'h87654321},
        {4'b1011, 32'hF0F00F0F, 32'h01234567},
        {4'b0111, 32'h0000BEEF, 32'hFFFF4BD2}
    };

    always #10 clk = ~clk;

    pcm_serial_port i_pcm_serial_port (
        .clk(clk), .rst_n(rst_n), .cfg_word32(c_w32), .cfg_msb_first(c_msb),
        .cfg_delayed(c_del), .cfg_wide_pulse(c_wide), .pcm_clk(pcm_clk),
        .pcm_frame(pcm_frame), .pcm_in(pcm_in), .pcm_out(pcm_out),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .underrun(underrun), .overrun(overrun), .frame_err(frame_err)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (underrun) n_udr++;
            if (overrun) n_ovr++;
            if (frame_err) n_err++;
            if (rx_valid && rx_ready) begin
                rx_log[rx_n[5:0]] <= rx_data;
                rx_n++;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int nbits();
        return c_w32 ? 32 : 16;
    endfunction

    function automatic int bpos(input int i);
        return c_msb ? nbits() - 1 - i : i;
    endfunction

    function automatic logic [31:0] wmask();
        return c_w32 ? 32'hFFFFFFFF : 32'h0000FFFF;
    endfunction

    task automatic clear_seq(input int len);
        for (int e = 0; e < 128; e++) begin
            fr_seq[e] = 0; din_seq[e] = 0; out_seq[e] = 0;
        end
        seq_len = len;
    endtask

    task automatic put_word(input int s, input logic [31:0] w);
        int d = c_del ? 1 : 0;
        if (c_wide) begin
            for (int e = s; e <= s + nbits() - 1 + d; e++) fr_seq[e] = 1;
        end else begin
            fr_seq[s] = 1;
        end
        for (int i = 0; i < nbits(); i++) din_seq[s + d + i] = w[bpos(i)];
    endtask

    function automatic logic [31:0] get_tx(input int s);
        logic [31:0] r = '0;
        int d = c_del ? 1 : 0;
        for (int i = 0; i < nbits(); i++) r[bpos(i)] = out_seq[s + d + i];
        return r;
    endfunction

    task automatic push_tx(input logic [31:0] w);
        @(negedge clk);
        tx_data = w;
        tx_valid = 1;
        @(negedge clk);
        tx_valid = 0;
    endtask

    task automatic bit_cycle(input logic fr, input logic d, output logic smp);
        pcm_frame = fr;
        pcm_in = d;
        repeat (4) @(negedge clk);
        smp = pcm_out;
        pcm_clk = 1;
        repeat (4) @(negedge clk);
        pcm_clk = 0;
    endtask

    task automatic play(input int push_at, input logic [31:0] push_word);
        logic s;
        for (int e = 0; e < seq_len; e++) begin
            if (e == push_at) push_tx(push_word);
            bit_cycle(fr_seq[e], din_seq[e], s);
            if (e > 0) out_seq[e-1] = s;
        end
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int u0, e0, o0, r0, last;
        repeat (5) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        // R1 reset state
        check("R1 tx_ready", 32'(tx_ready), 32'd1);
        check("R1 rx_valid", 32'(rx_valid), 32'd0);
        check("R1 pcm_out", 32'(pcm_out), 32'd0);
        check("R1 pulses", 32'(n_udr + n_ovr + n_err), 32'd0);

        // table walk: R2 R3 R4 R6 R8 R13
        for (int v = 0; v < 8; v++) begin
            {c_w32, c_msb, c_del, c_wide} = VEC[v][67:64];
            last = 1 + (c_del ? 1 : 0) + nbits() - 1;
            clear_seq(last + 3);
            put_word(1, VEC[v][31:0]);
            u0 = n_udr; e0 = n_err; o0 = n_ovr; r0 = rx_n;
            check("R8 ready before push", 32'(tx_ready), 32'd1);
            push_tx(VEC[v][63:32]);
            play(-1, '0);
            check("R2/R3/R4/R6 rx word", (rx_n == r0 + 1) ? rx_log[r0[5:0]] : 32'hBADBAD00,
                  VEC[v][31:0] & wmask());
            check("R2/R3/R4/R8 tx word", get_tx(1), VEC[v][63:32] & wmask());
            check("R13 idle line", {30'd0, out_seq[0], out_seq[last+1]}, 32'd0);
            check("R8 no pulses", 32'((n_udr - u0) + (n_err - e0) + (n_ovr - o0)), 32'd0);
        end

        // R9 underrun: no word supplied
        {c_w32, c_msb, c_del, c_wide} = 4'b0000;
        clear_seq(20);
        put_word(1, 32'h00005A5A);
        u0 = n_udr; r0 = rx_n;
        play(-1, '0);
        check("R9 zeros sent", get_tx(1), 32'd0);
        check("R9 underrun pulse", 32'(n_udr - u0), 32'd1);

        // R7 overrun: two words, none taken
        rx_ready = 0;
        clear_seq(40);
        put_word(1, 32'h00001111);
        put_word(20, 32'h00002222);
        o0 = n_ovr;
        push_tx(32'h0000AAAA);
        play(5, 32'h00005555);
        check("R6 valid held", 32'(rx_valid), 32'd1);
        check("R7 overrun pulse", 32'(n_ovr - o0), 32'd1);
        r0 = rx_n;
        rx_ready = 1;
        repeat (3) @(negedge clk);
        check("R7 newer word kept", (rx_n == r0 + 1) ? rx_log[r0[5:0]] : 32'hBADBAD00, 32'h00002222);
        check("R8 second tx word", get_tx(20), 32'h00005555);

        // R10 early frame strobe
        clear_seq(26);
        put_word(1, 32'h0000ABCD);
        put_word(7, 32'h00004321);
        e0 = n_err; u0 = n_udr; r0 = rx_n;
        push_tx(32'h0000FFFF);
        play(-1, '0);
        check("R10 error pulse", 32'(n_err - e0), 32'd1);
        check("R10 resync word", (rx_n == r0 + 1) ? rx_log[r0[5:0]] : 32'hBADBAD00, 32'h00004321);
        check("R10 new frame tx underrun", 32'(n_udr - u0), 32'd1);

        // R11 short strobe held for two edges
        clear_seq(20);
        put_word(1, 32'h00009876);
        fr_seq[2] = 1;
        e0 = n_err; r0 = rx_n;
        push_tx(32'h00000F0F);
        play(-1, '0);
        check("R11 error pulse", 32'(n_err - e0), 32'd1);
        check("R11 word kept", (rx_n == r0 + 1) ? rx_log[r0[5:0]] : 32'hBADBAD00, 32'h00009876);

        // R12 wide strobe falling early
        {c_w32, c_msb, c_del, c_wide} = 4'b1001;
        clear_seq(36);
        put_word(1, 32'hA0B0C0D0);
        for (int e = 12; e < 36; e++) fr_seq[e] = 0;
        e0 = n_err; r0 = rx_n;
        push_tx(32'h01020304);
        play(-1, '0);
        check("R12 error pulse", 32'(n_err - e0), 32'd1);
        check("R12 word kept", (rx_n == r0 + 1) ? rx_log[r0[5:0]] : 32'hBADBAD00, 32'hA0B0C0D0);
        check("R12 tx kept", get_tx(1), 32'h01020304);

        // R5 back-to-back delayed frames
        {c_w32, c_msb, c_del, c_wide} = 4'b0010;
        clear_seq(37);
        put_word(1, 32'h0000C3C3);
        put_word(17, 32'h00003C3D);
        e0 = n_err; r0 = rx_n;
        push_tx(32'h0000A1B2);
        play(4, 32'h0000C4D5);
        check("R5 no error", 32'(n_err - e0), 32'd0);
        check("R5 first word", (rx_n == r0 + 2) ? rx_log[r0[5:0]] : 32'hBADBAD00, 32'h0000C3C3);
        check("R5 second word", (rx_n == r0 + 2) ? rx_log[6'(r0 + 1)] : 32'hBADBAD00, 32'h00003C3D);
        check("R5 first tx", get_tx(1), 32'h0000A1B2);
        check("R5 second tx", get_tx(17), 32'h0000C4D5);

        done_flag = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule